// File: doc/BRIEF.md
# Indirect Register Window with Sequential Stepping

This block gives a host access to a bank of internal 16-bit registers through two ports in a small I/O window. The host first loads a pointer port with the byte address of the register it wants. The register at that address then appears at a separate data port, where the host can read or write it. Offsets in the window other than these two are inert.

Bit 15 of the pointer value selects sequential mode. When it is set, every completed data-port access moves the pointer forward by one 16-bit word (two bytes). A run of registers can then be streamed with back-to-back data-port accesses and no further pointer writes. When bit 15 is clear, the pointer stays on the same register.

Host traffic is carried as a valid/ready request stream and a valid/ready response stream. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. Exactly one response follows in the next cycle. The response is held, unchanged, until the host takes it with `rsp_ready`. While a response waits, `req_ready` is low, so requests are throttled to the pace at which responses are drained. `req_ready` does not depend on `req_valid`.

Top module: `iw_window`

## Requirements
- R1: After reset, the pointer is 0x0000, every internal register is 0x0000 and `rsp_valid` is low.
- R2: A write to offset 0xA loads all 16 bits of the pointer. A read of offset 0xA returns the full current pointer, including the sequential flag in bit 15.
- R3: A data-port access at offset 0xC reads or writes the register whose word index is (pointer[14:1] - REG_BASE[14:1]). Pointer bit 0 is ignored for addressing. With defaults, registers 0..7 sit at byte addresses 0x0100..0x010E.
- R4: When pointer bit 15 is 1, each accepted data-port access, read or write, adds 2 to pointer bits 14:0. The data of that access uses the address held before the step.
- R5: When pointer bit 15 is 0, data-port accesses leave the pointer unchanged.
- R6: The step wraps pointer bits 14:0 modulo 2^15 (0x7FFE steps to 0x0000) and never changes bit 15.
- R7: A data-port access whose address lies outside the mapped range reads 0x0000 and writes nothing.
- R8: Reads of any offset other than 0xA and 0xC return 0x0000. Writes to such offsets change neither the pointer nor any register.
- R9: Every accepted request produces exactly one response in the following cycle. Write responses carry 0x0000.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_rdata` holds steady, `req_ready` is low and no request is accepted. In the cycle where the response is taken, a new request may be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset in the host window |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | DATA_W | Read data, or 0 for writes |

## Verification
The hardest case to reach from the ports is a stalled data-port read in sequential mode while a second data request waits behind it. In that case the pointer must step exactly once per accepted access and not once per cycle the request is held. The bench holds `rsp_ready` low, issues a data read, and keeps a second data read asserted for several cycles. It confirms that the first response stays frozen and that the second request is taken only on release. It then reads the pointer back to show it moved two words and no more. Address wrap and the step past the last mapped register are reached by loading the pointer right next to those boundaries.

// File: rtl/iw_pkg.sv
package iw_pkg;
  localparam int OFF_W    = 4;
  localparam logic [OFF_W-1:0] PTR_OFF  = 4'hA;
  localparam logic [OFF_W-1:0] DATA_OFF = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_PTR  = 2'd1,
    SEL_DATA = 2'd2
  } port_sel_e;

  function automatic port_sel_e decode_offset(input logic [OFF_W-1:0] off);
    if (off == PTR_OFF)       return SEL_PTR;
    else if (off == DATA_OFF) return SEL_DATA;
    else                      return SEL_NONE;
  endfunction
endpackage

// File: rtl/iw_pointer.sv
module iw_pointer #(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  input  logic             step,
  output logic [PTR_W-1:0] ptr_q
);
  localparam int WORD_W = PTR_W - 2;

  logic             flag;
  logic [WORD_W-1:0] word_nxt;

  assign flag     = ptr_q[PTR_W-1];
  assign word_nxt = ptr_q[PTR_W-2:1] + WORD_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ptr_q <= '0;
    else if (load)         ptr_q <= load_val;
    else if (step && flag) ptr_q <= {flag, word_nxt, ptr_q[0]};
  end

  // R4: sequential step adds one word
  a_r4_step_word: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && flag) |=> (ptr_q[PTR_W-2:0] == $past(ptr_q[PTR_W-2:0]) + (PTR_W-1)'(2)));
  // R5: pointer holds without the flag
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !flag) |=> $stable(ptr_q));
  // R6: step never alters flag
  a_r6_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr_q[PTR_W-1] == $past(ptr_q[PTR_W-1])));
endmodule

// File: rtl/iw_regfile.sv
module iw_regfile #(
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 8,
  parameter int WADDR_W  = 14,
  parameter logic [WADDR_W-1:0] BASE_W = 14'h0080
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WADDR_W-1:0] waddr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic               hit
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DATA_W-1:0]  mem [NUM_REGS];
  logic [WADDR_W-1:0] rel;
  logic [IDX_W-1:0]   idx;

  assign rel   = waddr - BASE_W;
  assign hit   = (waddr >= BASE_W) && (rel < WADDR_W'(NUM_REGS));
  assign idx   = rel[IDX_W-1:0];
  assign rdata = hit ? mem[idx] : '0;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  mem[g] <= '0;
      else if (wr_en && hit && idx == IDX_W'(g))   mem[g] <= wdata;
    end
  end
endmodule

// File: rtl/iw_rsp.sv
module iw_rsp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              req_ready
);
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  // R10: stalled response is frozen
  a_r10_hold_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
  // R10: no acceptance while a response waits
  a_r10_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !accept);
  // R9: one response per accepted request
  a_r9_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);
endmodule

// File: rtl/iw_window.sv
module iw_window #(
  parameter int DATA_W   = 16,
  parameter int OFF_W    = iw_pkg::OFF_W,
  parameter int NUM_REGS = 8,
  parameter logic [15:0] REG_BASE = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata
);
  import iw_pkg::*;

  localparam int PTR_W   = DATA_W;
  localparam int WADDR_W = PTR_W - 2;
  localparam logic [WADDR_W-1:0] BASE_W = REG_BASE[PTR_W-2:1];

  logic              accept;
  port_sel_e         sel;
  logic [PTR_W-1:0]  ptr_q;
  logic [DATA_W-1:0] rf_rdata;
  logic              rf_hit;
  logic [DATA_W-1:0] rsp_next;
  logic              ptr_load, data_acc, data_wr;

  assign accept   = req_valid && req_ready;
  assign sel      = decode_offset(req_offset[3:0]);
  assign ptr_load = accept && req_write && (sel == SEL_PTR);
  assign data_acc = accept && (sel == SEL_DATA);
  assign data_wr  = data_acc && req_write;

  always_comb begin
    rsp_next = '0;
    if (!req_write) begin
      case (sel)
        SEL_PTR:  rsp_next = ptr_q;
        SEL_DATA: rsp_next = rf_rdata;
        default:  rsp_next = '0;
      endcase
    end
  end

  iw_pointer #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(req_wdata),
    .step(data_acc), .ptr_q(ptr_q)
  );

  iw_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .WADDR_W(WADDR_W), .BASE_W(BASE_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .waddr(ptr_q[PTR_W-2:1]), .wr_en(data_wr),
    .wdata(req_wdata), .rdata(rf_rdata), .hit(rf_hit)
  );

  iw_rsp #(.DATA_W(DATA_W)) u_rsp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .load_data(rsp_next),
    .rsp_ready(rsp_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .req_ready(req_ready)
  );

  // R7: unmapped data read returns zero
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !req_write && !rf_hit) |=> (rsp_rdata == '0));
  // R8: inert offsets leave the pointer alone
  a_r8_inert_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sel == SEL_NONE) |=> $stable(ptr_q));
  // R9: write responses carry zero
  a_r9_write_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |=> (rsp_rdata == '0));
endmodule

// File: tb/sim_iw_window.sv
`timescale 1ns/1ps
module sim_iw_window;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [3:0]  req_offset = 4'h0;
  logic [15:0] req_wdata = 16'h0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [15:0] rsp_rdata;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  iw_window u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  off;
    logic [15:0] wd;
    logic [15:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'hA, 16'h8100, 16'h0000, 4'd2},  // R2 load, flag on
    '{1'b1, 4'hC, 16'h1111, 16'h0000, 4'd9},  // R3 reg0, R9 write rsp 0
    '{1'b1, 4'hC, 16'h2222, 16'h0000, 4'd4},  // R4 reg1
    '{1'b1, 4'hC, 16'h3333, 16'h0000, 4'd4},  // R4 reg2
    '{1'b0, 4'hA, 16'h0000, 16'h8106, 4'd4},  // R4 three steps
    '{1'b1, 4'hA, 16'h0100, 16'h0000, 4'd2},  // R2 flag off
    '{1'b0, 4'hC, 16'h0000, 16'h1111, 4'd3},  // R3
    '{1'b0, 4'hC, 16'h0000, 16'h1111, 4'd5},  // R5 same reg
    '{1'b0, 4'hA, 16'h0000, 16'h0100, 4'd5},  // R5 pointer held
    '{1'b1, 4'hA, 16'h8102, 16'h0000, 4'd2},
    '{1'b0, 4'hC, 16'h0000, 16'h2222, 4'd4},  // R4 read stream
    '{1'b0, 4'hC, 16'h0000, 16'h3333, 4'd4},
    '{1'b0, 4'hA, 16'h0000, 16'h8106, 4'd4},
    '{1'b1, 4'hA, 16'h0200, 16'h0000, 4'd7},  // R7 unmapped
    '{1'b1, 4'hC, 16'hDEAD, 16'h0000, 4'd7},
    '{1'b0, 4'hC, 16'h0000, 16'h0000, 4'd7},  // R7 reads zero
    '{1'b0, 4'h0, 16'h0000, 16'h0000, 4'd8},  // R8 inert read
    '{1'b1, 4'h0, 16'hBEEF, 16'h0000, 4'd8},  // R8 inert write
    '{1'b0, 4'hA, 16'h0000, 16'h0200, 4'd8}   // R8 pointer untouched
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [3:0] off, input logic [15:0] wd,
                     output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_offset = off; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_rdata;
    if (!rsp_valid) chk("R9 rsp_valid", 16'(rsp_valid), 16'h1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    chk("R1 rsp_valid in reset", 16'(rsp_valid), 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", 16'(rsp_valid), 16'h0);
    acc(1'b0, 4'hA, 16'h0, rd); chk("R1 pointer", rd, 16'h0000);
    acc(1'b1, 4'hA, 16'h0104, rd);
    acc(1'b0, 4'hC, 16'h0, rd); chk("R1 reg2", rd, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      acc(TBL[i].we, TBL[i].off, TBL[i].wd, rd);
      chk($sformatf("R%0d vec %0d", TBL[i].rq, i), rd, TBL[i].exp);
    end

    // R3: last mapped register, then step out of range
    acc(1'b1, 4'hA, 16'h810E, rd);
    acc(1'b1, 4'hC, 16'h7777, rd);
    acc(1'b0, 4'hA, 16'h0, rd); chk("R4 past last", rd, 16'h8110);
    acc(1'b1, 4'hA, 16'h010E, rd);
    acc(1'b0, 4'hC, 16'h0, rd); chk("R3 last reg", rd, 16'h7777);
    // R3: odd pointer bit ignored
    acc(1'b1, 4'hA, 16'h0101, rd);
    acc(1'b0, 4'hC, 16'h0, rd); chk("R3 odd addr", rd, 16'h1111);
    // R6: wrap keeps flag
    acc(1'b1, 4'hA, 16'hFFFE, rd);
    acc(1'b0, 4'hC, 16'h0, rd); chk("R7 high miss", rd, 16'h0000);
    acc(1'b0, 4'hA, 16'h0, rd); chk("R6 wrap", rd, 16'h8000);
    acc(1'b1, 4'hA, 16'hFFFF, rd);
    acc(1'b1, 4'hC, 16'h5555, rd);
    acc(1'b0, 4'hA, 16'h0, rd); chk("R6 wrap odd", rd, 16'h8001);

    // R10: back-pressure with sequential stepping
    acc(1'b1, 4'hA, 16'h8100, rd);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_offset = 4'hC;
    @(posedge clk);
    @(negedge clk);
    chk("R10 first rsp", rsp_rdata, 16'h1111);
    chk("R10 ready low", 16'(req_ready), 16'h0);
    repeat (3) @(negedge clk);
    chk("R10 held data", rsp_rdata, 16'h1111);
    chk("R10 held valid", 16'(rsp_valid), 16'h1);
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 second rsp", rsp_rdata, 16'h2222);
    acc(1'b0, 4'hA, 16'h0, rd); chk("R10 two steps", rd, 16'h8104);

    finish_run();
  end
endmodule